// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial characters. Software-side logic writes a character byte into a holding slot and a format byte into a line-control slot, both through one write port. A framer takes the byte from the holding slot when it is free and sends a low start bit, then the data bits least-significant first, then an optional parity bit, then a high stop period.

Timing comes from a single-cycle baud tick that runs at sixteen times the bit rate. Each bit occupies sixteen ticks. The stop period is one bit long by default. The long-stop option makes it one and a half bits for 5-bit characters and two bits for all other lengths. Parity can be off, even, odd, forced low or forced high.

The format is sampled when a character begins, so a new format written while a character is on the line applies only to later characters. An active-low ready output shows when the holding slot can accept another byte.

Top module: `serial_tx_core`

## Requirements
- R1: A synchronous active-high reset drives `tx_line` high and `tx_rdy_n` low, empties the holding slot and the shifter, and sets the format to 5 data bits, no parity and a 1-bit stop period.
- R2: A character is a low start bit followed by the data bits, least-significant first. Every start, data and parity bit lasts exactly 16 ticks at a constant level.
- R3: Format bits [1:0] select the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Byte bits above the selected length are not sent.
- R4: When format bit 3 is 0, no parity bit is sent, and the stop period follows the last data bit directly.
- R5: When format bit 3 is 1 and bit 5 is 0, a parity bit is sent. Bit 4 = 1 selects even parity and bit 4 = 0 selects odd parity. Only the selected number of data bits are counted.
- R6: When format bits 3 and 5 are both 1, the parity bit is constant: 0 when bit 4 is 1, and 1 when bit 4 is 0.
- R7: The stop period is high. It lasts 16 ticks when format bit 2 is 0. When bit 2 is 1 it lasts 24 ticks for 5-bit characters and 32 ticks otherwise.
- R8: A write to address 0 loads the holding slot and drives `tx_rdy_n` high on the next clock. `tx_rdy_n` returns low on the tick at which the byte enters the shifter. A write to any address other than 0 or 3 changes neither the line nor `tx_rdy_n`.
- R9: An idle transmitter with a full holding slot starts the start bit on the next tick. A byte that is waiting when a stop period ends starts on the tick right after the last stop tick, with no extra idle time.
- R10: The format is captured when a character starts. A write to address 3 while a character is being sent does not change that character.
- R11: `tx_line` changes only on clock edges at which `tick_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Baud tick, one cycle wide, at 16 times the bit rate |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address: 0 = holding slot, 3 = format |
| wr_data | input | 8 | Write data |
| tx_line | output | 1 | Serial output; high when idle |
| tx_rdy_n | output | 1 | Low while the holding slot is empty |

## Verification
`tx_rdy_n` rises one clock after a write to the holding slot, and the bench samples it at the falling edge that follows that write. A character from an idle transmitter is due on the first tick after the write has been registered. For that reason the driver writes just after a tick edge and expects the start bit on the next tick. Characters written back to back are due exactly one full frame, counted in ticks, after the previous start bit. A monitor counts ticks from each start bit and compares the line level after every tick with the next value in a queue. It reports one result at the end of each bit and one at the end of each stop period.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // format byte fields, bits [5:0] of a control write
  typedef struct packed {
    logic       stick;
    logic       even;
    logic       par_en;
    logic       long_stop;
    logic [1:0] len;
  } line_cfg_t;

  localparam int MIN_CHAR_LEN = 5;

  function automatic line_cfg_t decode_cfg(input logic [5:0] raw);
    return line_cfg_t'(raw);
  endfunction

endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
  import sertx_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int ADDR_HOLD = 0,
  parameter int ADDR_CTRL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full,
  output line_cfg_t         cfg
);

  localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(ADDR_HOLD);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);

  logic wr_hold, wr_ctrl;
  logic unused_ctrl_hi;

  assign wr_hold        = wr_en && (wr_addr == A_HOLD);
  assign wr_ctrl        = wr_en && (wr_addr == A_CTRL);
  assign unused_ctrl_hi = ^wr_data[DATA_W-1:6];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_full <= 1'b0;
      cfg       <= '0;
    end else begin
      // a write in the same cycle as a load refills the slot
      if (wr_hold) begin
        hold_data <= wr_data;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end
      if (wr_ctrl) cfg <= decode_cfg(wr_data[5:0]);
    end
  end

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity #(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        len,
  input  logic              even,
  input  logic              stick,
  output logic              par_bit
);

  logic [DATA_W-1:0] mask;
  logic              ones_odd;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < MIN_LEN) begin : g_fixed
      assign mask[i] = 1'b1;
    end else begin : g_sel
      assign mask[i] = (32'(len) + MIN_LEN) > i;
    end
  end

  assign ones_odd = ^(data & mask);

  always_comb begin
    if (stick)     par_bit = ~even;
    else if (even) par_bit = ones_odd;
    else           par_bit = ~ones_odd;
  end

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  line_cfg_t         cfg,
  input  logic              par_in,
  output logic              load,
  output logic              line,
  output tx_state_e         state
);

  localparam int SUB_W = $clog2(2 * OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [SUB_W-1:0] BIT_LAST   = SUB_W'(OSR - 1);
  localparam logic [SUB_W-1:0] STOP_15    = SUB_W'(OSR + OSR / 2 - 1);
  localparam logic [SUB_W-1:0] STOP_20    = SUB_W'(2 * OSR - 1);
  localparam logic [IDX_W-1:0] IDX_BASE   = IDX_W'(MIN_CHAR_LEN - 1);

  tx_state_e         st;
  logic [SUB_W-1:0]  sub;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shf;
  logic [1:0]        len_q;
  logic              long_q, pen_q, par_q, line_q;
  logic [SUB_W-1:0]  stop_last;
  logic [IDX_W-1:0]  idx_last;
  logic              stop_done;

  always_comb begin
    if (!long_q)            stop_last = BIT_LAST;
    else if (len_q == 2'd0) stop_last = STOP_15;
    else                    stop_last = STOP_20;
  end

  assign idx_last  = IDX_BASE + IDX_W'(len_q);
  assign stop_done = (st == ST_STOP) && (sub == stop_last);
  assign load      = tick && hold_full && ((st == ST_IDLE) || stop_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      sub    <= '0;
      idx    <= '0;
      shf    <= '0;
      len_q  <= '0;
      long_q <= 1'b0;
      pen_q  <= 1'b0;
      par_q  <= 1'b0;
      line_q <= 1'b1;
    end else if (load) begin
      st     <= ST_START;
      sub    <= '0;
      idx    <= '0;
      shf    <= hold_data;
      len_q  <= cfg.len;
      long_q <= cfg.long_stop;
      pen_q  <= cfg.par_en;
      par_q  <= par_in;
      line_q <= 1'b0;
    end else if (tick) begin
      sub <= sub + 1'b1;
      unique case (st)
        ST_IDLE: sub <= '0;
        ST_START: if (sub == BIT_LAST) begin
          sub    <= '0;
          st     <= ST_DATA;
          line_q <= shf[0];
        end
        ST_DATA: if (sub == BIT_LAST) begin
          sub <= '0;
          if (idx == idx_last) begin
            if (pen_q) begin
              st     <= ST_PAR;
              line_q <= par_q;
            end else begin
              st     <= ST_STOP;
              line_q <= 1'b1;
            end
          end else begin
            idx    <= idx + 1'b1;
            shf    <= shf >> 1;
            line_q <= shf[1];
          end
        end
        ST_PAR: if (sub == BIT_LAST) begin
          sub    <= '0;
          st     <= ST_STOP;
          line_q <= 1'b1;
        end
        ST_STOP: if (sub == stop_last) begin
          sub <= '0;
          st  <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign line  = line_q;
  assign state = st;

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import sertx_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int OSR       = 16,
  parameter int ADDR_HOLD = 0,
  parameter int ADDR_CTRL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_line,
  output logic              tx_rdy_n
);

  logic [DATA_W-1:0] hold_data;
  logic              hold_full, load, par_bit;
  line_cfg_t         cfg;
  tx_state_e         frm_state;

  sertx_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_HOLD(ADDR_HOLD), .ADDR_CTRL(ADDR_CTRL)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(load), .hold_data(hold_data),
    .hold_full(hold_full), .cfg(cfg)
  );

  sertx_parity #(.DATA_W(DATA_W), .MIN_LEN(MIN_CHAR_LEN)) u_par (
    .data(hold_data), .len(cfg.len), .even(cfg.even),
    .stick(cfg.stick), .par_bit(par_bit)
  );

  sertx_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_frm (
    .clk(clk), .rst(rst), .tick(tick_en), .hold_full(hold_full),
    .hold_data(hold_data), .cfg(cfg), .par_in(par_bit),
    .load(load), .line(tx_line), .state(frm_state)
  );

  // the holding-full flop drives the ready pin directly
  assign tx_rdy_n = hold_full;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int ADDR_W    = 3,
  parameter int ADDR_HOLD = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              tx_line,
  input logic              tx_rdy_n,
  input logic              in_stop
);

  // R1
  line_idle_after_rst_chk: assert property (@(posedge clk)
    $past(rst) |-> (tx_line && !tx_rdy_n));

  // R11
  line_held_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !rst) |=> $stable(tx_line));

  // R8
  ready_clear_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(ADDR_HOLD)) |=> tx_rdy_n);

  // R8
  ready_set_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(tx_rdy_n) && !$past(rst)) |-> $past(tick_en));

  // R7
  stop_level_high_chk: assert property (@(posedge clk) disable iff (rst)
    in_stop |-> tx_line);

endmodule

bind serial_tx_core sertx_chk #(.ADDR_W(ADDR_W), .ADDR_HOLD(ADDR_HOLD)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .tx_line(tx_line), .tx_rdy_n(tx_rdy_n),
  .in_stop(frm_state == sertx_pkg::ST_STOP)
);

// File: tb/test_serial_tx_core.sv
module test_serial_tx_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tx_line, tx_rdy_n;

  always #10 clk = ~clk;

  serial_tx_core i_serial_tx_core (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tx_line(tx_line), .tx_rdy_n(tx_rdy_n)
  );

  typedef struct {
    int          nbits;
    logic [11:0] lv;
    int          total;
    int          start_exp;
    bit          b2b;
    string       preq;
  } frame_t;

  frame_t     q[$];
  int         n_chk = 0, n_fail = 0;
  int         tick_no = 0, frames_done = 0, prev_end = 0;
  bit         active = 1'b0;
  logic [7:0] cur_lcr = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [7:0] mk_lcr(input int len, input bit lng, input bit pen,
                                         input bit even, input bit stick);
    logic [1:0] code = 2'(len - 5);
    return {2'b00, stick, even, pen, lng, code};
  endfunction

  function automatic frame_t mk_frame(input logic [7:0] d, input logic [7:0] lcr,
                                      input bit b2b, input int start_exp);
    frame_t f;
    int n = 5 + int'(lcr[1:0]);
    int ones = 0;
    logic p;
    f.lv = '1;
    f.lv[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      f.lv[1+i] = d[i];
      ones += int'(d[i]);
    end
    if (lcr[5]) p = ~lcr[4];
    else        p = lcr[4] ? logic'(ones % 2) : ~logic'(ones % 2);
    f.preq  = lcr[5] ? "R6 stick parity bit" : "R5 parity bit";
    f.nbits = 1 + n + int'(lcr[3]);
    if (lcr[3]) f.lv[n+1] = p;
    f.total = 16 * f.nbits + (!lcr[2] ? 16 : (n == 5 ? 24 : 32));
    f.b2b = b2b;
    f.start_exp = start_exp;
    return f;
  endfunction

  // baud tick: one clock high in four
  initial forever begin
    repeat (3) @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  end

  always @(posedge clk) if (tick_en) tick_no <= tick_no + 1;

  // monitor: pops the expected frame at each start bit
  initial begin
    frame_t f;
    int k = 0, st = 0, seen = 0, expv = 1;
    bit bad = 0, drift = 0;
    logic last = 1'b1;
    forever begin
      @(negedge clk);
      if (tick_no != seen) begin
        seen = tick_no;
        if (!active) begin
          if (tx_line === 1'b0) begin
            if (q.size() == 0) begin
              chk(1'b0, "R9 unexpected start bit", 0, 1);
            end else begin
              f = q.pop_front();
              st = tick_no; k = 0; bad = 0; drift = 0; active = 1'b1;
              expv = f.b2b ? prev_end : f.start_exp;
              chk(st == expv, "R9 start tick", st, expv);
              chk(tx_rdy_n === 1'b0, "R8 ready on load", int'(tx_rdy_n), 0);
            end
          end
        end else begin
          k++;
          expv = (k / 16 < f.nbits) ? int'(f.lv[k/16]) : 1;
          if (tx_line !== logic'(expv)) bad = 1;
          if (k / 16 < f.nbits && k % 16 == 15) begin
            if (k / 16 == 0) chk(!bad, "R2 start bit", int'(tx_line), expv);
            else if (k / 16 < f.nbits - 1 || f.lv[f.nbits-1] === 1'bx || f.preq == "")
              chk(!bad, "R2 R3 data bit", int'(tx_line), expv);
            else chk(!bad, "R2 R3 R5 R6 data or parity bit", int'(tx_line), expv);
            bad = 0;
          end
          if (k == f.total - 1) begin
            chk(!bad, "R7 stop period (R4 when parity off)", int'(tx_line), 1);
            chk(!drift, "R11 line held between ticks", int'(drift), 0);
            active = 1'b0;
            prev_end = st + f.total;
            frames_done++;
          end
        end
        last = tx_line;
      end else if (active && tx_line !== last) begin
        drift = 1;
      end
    end
  end

  task automatic send(input logic [7:0] d, input bit b2b);
    int se = 0;
    if (!b2b) begin
      do @(negedge clk); while (active || q.size() != 0);
      @(posedge clk iff tick_en);
      @(negedge clk);
      se = tick_no + 1;
    end else begin
      do @(negedge clk); while (tx_rdy_n !== 1'b0);
    end
    q.push_back(mk_frame(d, cur_lcr, b2b, se));
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(tx_rdy_n === 1'b1, "R8 busy after write", int'(tx_rdy_n), 1);
  endtask

  task automatic write_lcr(input logic [7:0] v);
    do @(negedge clk); while (q.size() != 0);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    cur_lcr = v;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (active || q.size() != 0);
  endtask

  initial begin
    int fd;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_line === 1'b1, "R1 line idle after reset", int'(tx_line), 1);
    chk(tx_rdy_n === 1'b0, "R1 ready after reset", int'(tx_rdy_n), 0);
    send(8'h15, 0);                              // R1 default format
    write_lcr(mk_lcr(5, 0, 1, 1, 0)); send(8'h15, 0);  // R5 even, parity 1
    write_lcr(mk_lcr(5, 1, 1, 0, 0)); send(8'h0A, 0);  // R5 odd, R7 24 ticks
    write_lcr(mk_lcr(5, 1, 1, 1, 1)); send(8'h1F, 0);  // R6 stick low
    write_lcr(mk_lcr(5, 0, 1, 0, 1)); send(8'h00, 0);  // R6 stick high
    write_lcr(mk_lcr(6, 1, 1, 1, 0)); send(8'h2C, 0);  // R3 R7 32 ticks
    write_lcr(mk_lcr(7, 1, 0, 0, 0)); send(8'h55, 0);  // R4
    write_lcr(mk_lcr(8, 0, 1, 0, 0)); send(8'hA7, 0);
    write_lcr(mk_lcr(8, 1, 1, 0, 1)); send(8'h3C, 0);
    write_lcr(mk_lcr(5, 0, 0, 0, 0)); send(8'hE5, 0);  // R3 high bits dropped
    write_lcr(mk_lcr(8, 1, 1, 1, 0));                  // R9 back to back
    send(8'h81, 0); send(8'h7E, 1); send(8'hC3, 1);
    write_lcr(mk_lcr(8, 0, 1, 1, 0));                  // R10 mid-frame change
    send(8'h96, 0);
    do @(negedge clk); while (!active);
    write_lcr(mk_lcr(5, 0, 0, 0, 0));
    send(8'h13, 0);
    wait_idle();
    fd = frames_done;                                  // R8 other address ignored
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'hAA;
    @(negedge clk);
    wr_en = 1'b0;
    chk(tx_rdy_n === 1'b0, "R8 ignored address keeps ready", int'(tx_rdy_n), 0);
    repeat (100) @(negedge clk);
    chk(tx_line === 1'b1, "R8 ignored address keeps line idle", int'(tx_line), 1);
    chk(frames_done == fd, "R8 ignored address sends nothing", frames_done, fd);
    finish_up();
  end

  initial begin
    #(20ns * 150000);
    n_fail++;
    $display("FAIL watchdog R1-R11 all: actual timeout expected completion");
    finish_up();
  end

endmodule